// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the serial clock of an I2C controller from a faster source clock. A control word sets the phase lengths. An 8-bit base divider sets the length of the low phase. An optional 8-bit high-period field sets a shorter high phase, which gives the roughly one-third high, two-thirds low split that fast and fast-plus modes use. When the high-period field is zero, both phases use the base divider and the duty cycle is 50 %, as standard mode needs. Every phase carries a fixed offset of three source cycles.

Software derives the fields from the source and bus frequencies. For standard mode the base divider is (src/f)/2 − 3. For fast mode the base divider is ((src/f) − 6)·2/3, and the high field is half of that. With the default 19.2 MHz source, bus rates up to 1 MHz can be reached.

The block drives the line open-drain style. It pulls SCL low during the low phase and releases it for the high phase. It does not count the high phase until the sensed line really reads high, so a target that holds SCL low stretches the clock. It also emits two one-cycle strobes: one in the middle of each low phase, where SDA may change, and one in the middle of each counted high phase, where SDA is sampled.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted or enable is low, `scl_out_o` is 1 (line released), and both strobes are 0.
- R2: Each low phase holds `scl_out_o` at 0 for exactly D+3 source cycles, where D is control bits [7:0]. A low phase is never extended.
- R3: When control bits [23:16] hold a nonzero value P, the counted high phase lasts P+3 source cycles.
- R4: When control bits [23:16] are zero, the counted high phase lasts D+3 source cycles, which gives a 50 % duty cycle.
- R5: After release, the high-phase count starts only in the first cycle in which `scl_in_i` reads 1. Each earlier cycle with `scl_in_i` at 0 lengthens the high level of `scl_out_o` by one cycle.
- R6: `sda_chg_o` pulses exactly once per low phase, in low-phase cycle floor((D+3)/2), counting the first low cycle as 0.
- R7: `sda_smp_o` pulses exactly once per high phase, in counted high cycle floor(H/2), where H is the high length from R3 or R4 and the first cycle with `scl_in_i` high is cycle 0.
- R8: Control bits [15:8], which include the high-speed divider field in bits [10:8], have no effect on phase lengths or strobe positions.
- R9: When enable goes low, the line is released at the next clock edge. When enable rises again, the block first drives a complete low phase of D+3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run the clock generator |
| ctrl_i | input | 24 | Control word: [7:0] base divider, [15:8] ignored, [23:16] high-period field |
| scl_in_i | input | 1 | Sensed level of the SCL line |
| scl_out_o | output | 1 | 0 drives SCL low, 1 releases it |
| sda_chg_o | output | 1 | One-cycle strobe at mid-low, where SDA may change |
| sda_smp_o | output | 1 | One-cycle strobe at mid-high, where SDA is sampled |

## Verification
The bench builds the block with its default parameters: an 8-bit base divider, an 8-bit high field at bit 16, and an offset of 3. With these values it can use divider settings that give phases of only a few cycles. The smallest setting, a base divider of 0, makes both phases 3 cycles long and puts each strobe in cycle 1. The asymmetric fast-mode split, a stretch of several cycles from the sensed line, and words with every ignored bit set can all be checked against a behavioural model on every clock.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_len_decode.sv
module scl_len_decode #(
    parameter int CTRL_W = 24,
    parameter int DIV_W  = 8,
    parameter int HI_LSB = 16,
    parameter int HI_W   = 8,
    parameter int OFFSET = 3,
    parameter int LEN_W  = 10
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [LEN_W-1:0]  low_len_o,
    output logic [LEN_W-1:0]  high_len_o
);

    logic [LEN_W-1:0] base_len;

    assign base_len  = LEN_W'(ctrl_i[DIV_W-1:0]) + LEN_W'(OFFSET);
    assign low_len_o = base_len;

    generate
        if (HI_W > 0) begin : g_split_duty
            logic [HI_W-1:0] hi_field;
            assign hi_field   = ctrl_i[HI_LSB +: HI_W];
            assign high_len_o = (hi_field == '0) ? base_len
                                                 : LEN_W'(hi_field) + LEN_W'(OFFSET);
        end else begin : g_even_duty
            assign high_len_o = base_len;
        end
    endgenerate

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_timing_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             scl_in_i,
    input  logic [LEN_W-1:0] low_len_i,
    input  logic [LEN_W-1:0] high_len_i,
    output scl_phase_e       phase_o,
    output logic [LEN_W-1:0] cnt_o,
    output logic             scl_rel_o
);

    typedef struct packed {
        scl_phase_e       phase;
        logic [LEN_W-1:0] cnt;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!en_i) begin
            nxt_d.phase = PH_IDLE;
            nxt_d.cnt   = '0;
        end else begin
            unique case (cur_q.phase)
                PH_IDLE: begin
                    nxt_d.phase = PH_LOW;
                    nxt_d.cnt   = '0;
                end
                PH_LOW: begin
                    if (cur_q.cnt == low_len_i - LEN_W'(1)) begin
                        nxt_d.phase = PH_WAIT;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + LEN_W'(1);
                    end
                end
                PH_WAIT: begin
                    if (scl_in_i) begin
                        nxt_d.phase = PH_HIGH;
                        nxt_d.cnt   = LEN_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cur_q.cnt == high_len_i - LEN_W'(1)) begin
                        nxt_d.phase = PH_LOW;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + LEN_W'(1);
                    end
                end
                default: begin
                    nxt_d.phase = PH_IDLE;
                    nxt_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign phase_o   = cur_q.phase;
    assign cnt_o     = cur_q.cnt;
    assign scl_rel_o = (cur_q.phase != PH_LOW);

    // R1
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> scl_rel_o);

    // R2
    low_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && cur_q.phase == PH_LOW && cur_q.cnt < low_len_i - LEN_W'(1))
        |=> !scl_rel_o);

    // R5
    stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && cur_q.phase == PH_WAIT && !scl_in_i) |=> scl_rel_o);

    // R3
    high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && cur_q.phase == PH_HIGH && cur_q.cnt < high_len_i - LEN_W'(1))
        |=> scl_rel_o);

endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
    import scl_timing_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  scl_phase_e       phase_i,
    input  logic [LEN_W-1:0] cnt_i,
    input  logic [LEN_W-1:0] low_len_i,
    input  logic [LEN_W-1:0] high_len_i,
    output logic             chg_o,
    output logic             smp_o
);

    logic [LEN_W-1:0] low_mid, high_mid;

    assign low_mid  = low_len_i >> 1;
    assign high_mid = high_len_i >> 1;

    assign chg_o = (phase_i == PH_LOW)  && (cnt_i == low_mid);
    assign smp_o = (phase_i == PH_HIGH) && (cnt_i == high_mid);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CTRL_W = 24,
    parameter int DIV_W  = 8,
    parameter int HI_LSB = 16,
    parameter int HI_W   = 8,
    parameter int OFFSET = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              scl_in_i,
    output logic              scl_out_o,
    output logic              sda_chg_o,
    output logic              sda_smp_o
);

    localparam int FIELD_W = (DIV_W > HI_W) ? DIV_W : HI_W;
    localparam int LEN_W   = FIELD_W + 2;

    logic [LEN_W-1:0] low_len, high_len, cnt;
    scl_phase_e       phase;

    scl_len_decode #(
        .CTRL_W (CTRL_W),
        .DIV_W  (DIV_W),
        .HI_LSB (HI_LSB),
        .HI_W   (HI_W),
        .OFFSET (OFFSET),
        .LEN_W  (LEN_W)
    ) i_decode (
        .ctrl_i     (ctrl_i),
        .low_len_o  (low_len),
        .high_len_o (high_len)
    );

    scl_phase_seq #(
        .LEN_W (LEN_W)
    ) i_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .scl_in_i   (scl_in_i),
        .low_len_i  (low_len),
        .high_len_i (high_len),
        .phase_o    (phase),
        .cnt_o      (cnt),
        .scl_rel_o  (scl_out_o)
    );

    scl_strobe_gen #(
        .LEN_W (LEN_W)
    ) i_strobe (
        .phase_i    (phase),
        .cnt_i      (cnt),
        .low_len_i  (low_len),
        .high_len_i (high_len),
        .chg_o      (sda_chg_o),
        .smp_o      (sda_smp_o)
    );

    // R6
    chg_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_chg_o |-> !scl_out_o);

    // R7
    smp_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_smp_o |-> scl_out_o);

    // R8
    ctrl_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |-> !$isunknown(ctrl_i));

endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [23:0] ctrl = '0;
    logic        hold = 1'b0;
    logic        scl_out, chg, smp, scl_line;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    assign scl_line = scl_out & ~hold;

    scl_timing_gen i_scl_timing_gen (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_i      (en),
        .ctrl_i    (ctrl),
        .scl_in_i  (scl_line),
        .scl_out_o (scl_out),
        .sda_chg_o (chg),
        .sda_smp_o (smp)
    );

    function automatic int len_lo(logic [23:0] c);
        return int'(c[7:0]) + 3;
    endfunction

    function automatic int len_hi(logic [23:0] c);
        return (c[23:16] == 8'd0) ? int'(c[7:0]) + 3 : int'(c[23:16]) + 3;
    endfunction

    // behavioural reference: mode 0 idle, 1 low, 2 released awaiting line, 3 counted high
    int m_mode = 0;
    int m_pos  = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0;
            m_pos  = 0;
        end else if (!en) begin
            m_mode = 0;
            m_pos  = 0;
        end else begin
            bit line_hi;
            line_hi = (m_mode != 1) && !hold;
            case (m_mode)
                0: begin m_mode = 1; m_pos = 0; end
                1: if (m_pos == len_lo(ctrl) - 1) begin m_mode = 2; m_pos = 0; end
                   else m_pos++;
                2: if (line_hi) begin m_mode = 3; m_pos = 1; end
                default: if (m_pos == len_hi(ctrl) - 1) begin m_mode = 1; m_pos = 0; end
                   else m_pos++;
            endcase
        end
    end

    // run lengths and strobe counts observed on the outputs
    int run = 0;
    bit prev_scl = 1'b1;
    int last_low = 0, last_high = 0;
    int chg_run = 0, smp_run = 0, last_chg = 0, last_smp = 0;

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            bit e_scl, e_chg, e_smp;
            e_scl = (m_mode != 1);
            e_chg = (m_mode == 1) && (m_pos == len_lo(ctrl) / 2);
            e_smp = (m_mode == 3) && (m_pos == len_hi(ctrl) / 2);
            check("R2 R5 R9 model scl", int'(scl_out), int'(e_scl));
            check("R6 model chg", int'(chg), int'(e_chg));
            check("R7 model smp", int'(smp), int'(e_smp));
            if (scl_out != prev_scl) begin
                if (prev_scl) begin
                    last_high = run; last_smp = smp_run;
                end else begin
                    last_low = run; last_chg = chg_run;
                end
                run = 1; chg_run = 0; smp_run = 0;
            end else begin
                run++;
            end
            if (chg) chg_run++;
            if (smp) smp_run++;
            prev_scl = scl_out;
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise();
        while (scl_out !== 1'b0) @(negedge clk);
        while (scl_out !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_fall();
        while (scl_out !== 1'b1) @(negedge clk);
        while (scl_out !== 1'b0) @(negedge clk);
    endtask

    initial begin
        cycles(4);
        // R1 reset state
        check("R1 scl in reset", int'(scl_out), 1);
        check("R1 chg in reset", int'(chg), 0);
        check("R1 smp in reset", int'(smp), 0);
        rst_n = 1'b1;
        cycles(3);
        check("R1 scl disabled", int'(scl_out), 1);

        // standard mode: D=5, no high field -> 8/8
        ctrl = {8'd0, 8'h03, 8'd5};
        en = 1'b1;
        cycles(60);
        wait_rise();
        check("R2 low len std", last_low, 8);
        check("R6 chg per low", last_chg, 1);
        wait_fall();
        check("R4 high len std", last_high, 8);
        check("R7 smp per high", last_smp, 1);

        // R9 disable releases next edge
        wait_fall();
        en = 1'b0;
        @(posedge clk); #1;
        check("R9 release after disable", int'(scl_out), 1);
        cycles(3);

        // fast mode: D=10, P=5 -> 13 low, 8 high
        ctrl = {8'd5, 8'h03, 8'd10};
        en = 1'b1;
        wait_rise();
        check("R9 full low after enable", last_low, 13);
        cycles(60);
        wait_rise();
        check("R2 low len fast", last_low, 13);
        wait_fall();
        check("R3 high len fast", last_high, 8);

        // R5 stretch by 6 cycles
        wait_rise();
        hold = 1'b1;
        cycles(6);
        hold = 1'b0;
        wait_fall();
        check("R5 stretched high", last_high, 14);
        check("R7 smp once stretched", last_smp, 1);

        // R8 ignored bits all set
        ctrl = {8'd5, 8'hFF, 8'd10};
        cycles(60);
        wait_rise();
        check("R8 low len ignored bits", last_low, 13);
        wait_fall();
        check("R8 high len ignored bits", last_high, 8);

        // minimum divider: 3/3
        ctrl = {8'd0, 8'h00, 8'd0};
        cycles(30);
        wait_rise();
        check("R2 low len min", last_low, 3);
        check("R6 chg min", last_chg, 1);
        wait_fall();
        check("R4 high len min", last_high, 3);
        check("R7 smp min", last_smp, 1);

        en = 1'b0;
        cycles(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule